// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 interrupt request lines and presents a single active-high interrupt to a processor. Each request is captured into a status register, either on a rising edge or while the line is high, as selected per input at build time. An enable register masks the captured requests. The masked result is visible as a pending register, and a vector register reports the number of the winning pending input.

Software reaches the block through a simple 32-bit word bus with a write strobe and a combinational read port. Enable bits can be written as a whole or changed atomically through a write-one-to-set and a write-one-to-clear alias. Captured requests are retired through an acknowledge alias. A two-bit master control register arms capture from the input pins and the output to the processor separately.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset the status, enable and master control registers read zero, the vector register reads 0xFFFFFFFF and `irq_out` is low.
- R2: A level-sensitive input (`EDGE_MASK` bit 0) that is high at a clock edge while capture is armed sets its status bit at that edge; the bit stays set until acknowledged.
- R3: An edge-sensitive input (`EDGE_MASK` bit 1) sets its status bit only at a low-to-high transition; a line held high after its bit is acknowledged does not set it again.
- R4: A write to the acknowledge alias (byte offset 0x0C) clears every status bit whose mask bit is 1; writing all ones clears every captured request.
- R5: A level-sensitive bit acknowledged while its input is still high and capture is armed reads as set again after that write.
- R6: When a rising edge on an edge-sensitive input and an acknowledge of the same bit fall in the same cycle, the status bit ends up set.
- R7: A write to the set alias (0x10) sets the enable bits whose mask bit is 1, a write to the clear alias (0x14) clears them; every other enable bit keeps its value.
- R8: A write to the enable register (0x08) replaces all enable bits; writing zero disables every input at once.
- R9: The pending register (0x04) reads status AND enable.
- R10: The vector register (0x18) reads the index of the lowest-numbered set pending bit as a number, or all ones when no bit is pending.
- R11: In the master control register (0x1C) bit 0 allows `irq_out` and bit 1 arms capture from the input pins; `irq_out` is high exactly when bit 0 is set and any bit is pending, and with bit 1 clear no status bit becomes set.
- R12: The status register sits at 0x00; the three aliases (0x0C, 0x10, 0x14) read zero; register bits above the input count read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IN | Interrupt request lines |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq_out | output | 1 | Interrupt to the processor, active high |

## Verification
The hardest situation to reach is a rising edge on an edge-sensitive input landing in exactly the cycle an acknowledge of the same bit is written. The bench first leaves the bit captured by a short pulse, then in one falling-edge slot both raises the line and issues the acknowledge write, so both reach the capture logic at the same clock edge. The same care is taken for a level line that is acknowledged while still held high, and for capture with the input arm bit cleared, each checked against a bench model on every cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    // word index of each register (byte address bits [4:2])
    typedef enum logic [2:0] {
        SEL_STATUS  = 3'd0,
        SEL_PENDING = 3'd1,
        SEL_ENABLE  = 3'd2,
        SEL_ACK     = 3'd3,
        SEL_EN_SET  = 3'd4,
        SEL_EN_CLR  = 3'd5,
        SEL_VECTOR  = 3'd6,
        SEL_MASTER  = 3'd7
    } reg_sel_e;

    localparam int MST_OUT_BIT = 0;
    localparam int MST_ARM_BIT = 1;

endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
    parameter int          NUM_IN    = 8,
    parameter logic [31:0] EDGE_MASK = 32'h0000_000F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              arm_i,
    input  logic [NUM_IN-1:0] ack_mask_i,
    output logic [NUM_IN-1:0] status_o
);

    localparam logic [NUM_IN-1:0] EDG_BITS = EDGE_MASK[NUM_IN-1:0];
    localparam logic [NUM_IN-1:0] LVL_BITS = ~EDG_BITS;

    typedef struct packed {
        logic [NUM_IN-1:0] status;
        logic [NUM_IN-1:0] prev;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [NUM_IN-1:0] hit;
    logic [NUM_IN-1:0] hit_gated;

    // per-input sensitivity chosen at build time
    for (genvar i = 0; i < NUM_IN; i++) begin : g_sense
        if (EDGE_MASK[i]) begin : g_edge
            assign hit[i] = irq_in[i] & ~cap_q.prev[i];
        end else begin : g_level
            assign hit[i] = irq_in[i];
        end
    end

    assign hit_gated = arm_i ? hit : '0;

    always_comb begin
        cap_d        = cap_q;
        cap_d.prev   = irq_in;
        // a new request outranks an acknowledge in the same cycle
        cap_d.status = (cap_q.status & ~ack_mask_i) | hit_gated;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign status_o = cap_q.status;

    p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_mask_i) |=> ((status_o & $past(ack_mask_i & ~hit_gated)) == '0));

    p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> ((status_o & $past(irq_in & LVL_BITS)) == $past(irq_in & LVL_BITS)));

    p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> ((status_o & $past(irq_in & ~cap_q.prev & EDG_BITS))
                   == $past(irq_in & ~cap_q.prev & EDG_BITS)));

    p_no_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> ((status_o & ~$past(status_o)) == '0));

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NUM_IN = 8,
    parameter int IDX_W  = 3
) (
    input  logic [NUM_IN-1:0] req_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              valid_o
);

    // scan from the top so the lowest set bit is written last
    always_comb begin
        idx_o   = '0;
        valid_o = |req_i;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
    import irq_ctrl_pkg::*;
#(
    parameter int          NUM_IN    = 8,
    parameter logic [31:0] EDGE_MASK = 32'h0000_000F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              bus_we,
    input  logic [4:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_out
);

    localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

    typedef struct packed {
        logic [NUM_IN-1:0] enable;
        logic [1:0]        master;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    reg_sel_e          sel;
    logic              aligned;
    logic              wr_hit;
    logic [NUM_IN-1:0] wmask;
    logic [NUM_IN-1:0] ack_mask;
    logic [NUM_IN-1:0] status;
    logic [NUM_IN-1:0] pending;
    logic [IDX_W-1:0]  vec_idx;
    logic              vec_valid;
    logic              unused_wdata;

    assign sel          = reg_sel_e'(bus_addr[4:2]);
    assign aligned      = (bus_addr[1:0] == 2'b00);
    assign wr_hit       = bus_we & aligned;
    assign wmask        = bus_wdata[NUM_IN-1:0];
    assign unused_wdata = ^bus_wdata;
    assign ack_mask     = (wr_hit && sel == SEL_ACK) ? wmask : '0;

    irq_capture #(
        .NUM_IN    (NUM_IN),
        .EDGE_MASK (EDGE_MASK)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .arm_i      (ctl_q.master[MST_ARM_BIT]),
        .ack_mask_i (ack_mask),
        .status_o   (status)
    );

    assign pending = status & ctl_q.enable;

    irq_prio_enc #(
        .NUM_IN (NUM_IN),
        .IDX_W  (IDX_W)
    ) u_prio (
        .req_i   (pending),
        .idx_o   (vec_idx),
        .valid_o (vec_valid)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wr_hit) begin
            case (sel)
                SEL_ENABLE: ctl_d.enable = wmask;
                SEL_EN_SET: ctl_d.enable = ctl_q.enable | wmask;
                SEL_EN_CLR: ctl_d.enable = ctl_q.enable & ~wmask;
                SEL_MASTER: ctl_d.master = bus_wdata[1:0];
                default:    ctl_d = ctl_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (sel)
                SEL_STATUS:  bus_rdata = DATA_W'(status);
                SEL_PENDING: bus_rdata = DATA_W'(pending);
                SEL_ENABLE:  bus_rdata = DATA_W'(ctl_q.enable);
                SEL_VECTOR:  bus_rdata = vec_valid ? DATA_W'(vec_idx) : '1;
                SEL_MASTER:  bus_rdata = DATA_W'(ctl_q.master);
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign irq_out = ctl_q.master[MST_OUT_BIT] & vec_valid;

    p_set_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && sel == SEL_EN_SET) |=>
        ((ctl_q.enable & $past(wmask)) == $past(wmask)) &&
        ((ctl_q.enable & ~$past(wmask)) == ($past(ctl_q.enable) & ~$past(wmask))));

    p_clr_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && sel == SEL_EN_CLR) |=>
        ((ctl_q.enable & $past(wmask)) == '0) &&
        ((ctl_q.enable & ~$past(wmask)) == ($past(ctl_q.enable) & ~$past(wmask))));

    p_vec_win_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> pending[vec_idx]);

    p_vec_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (status & ctl_q.enable) == '0);

    p_out_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.master[MST_OUT_BIT] |-> !irq_out);

endmodule

// File: tb/irq_ctrl_top_test.sv
module irq_ctrl_top_test;

    localparam int          N    = 8;
    localparam logic [31:0] EDGE = 32'h0000_000F;

    localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_EN = 5'h08,
                           A_ACK = 5'h0C, A_SET = 5'h10, A_CLR = 5'h14,
                           A_VEC = 5'h18, A_MST = 5'h1C;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic         bus_we = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_ctrl_top #(.NUM_IN(N), .EDGE_MASK(EDGE)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    // behavioural reference model
    bit m_stat[N];
    bit m_en[N];
    bit m_prev[N];
    bit m_out, m_arm;

    function automatic int m_vec();
        for (int i = 0; i < N; i++) if (m_stat[i] && m_en[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a);
        logic [31:0] r;
        int v;
        r = 0;
        case (a)
            A_STAT: for (int i = 0; i < N; i++) r[i] = m_stat[i];
            A_PEND: for (int i = 0; i < N; i++) r[i] = m_stat[i] & m_en[i];
            A_EN:   for (int i = 0; i < N; i++) r[i] = m_en[i];
            A_VEC: begin v = m_vec(); r = (v < 0) ? 32'hFFFF_FFFF : 32'(v); end
            A_MST:  r = {30'd0, m_arm, m_out};
            default: r = 0;
        endcase
        return r;
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin : model_step
        bit nxt[N];
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_stat[i] = 0; m_en[i] = 0; m_prev[i] = 0; end
            m_out = 0; m_arm = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                bit rise;
                rise = EDGE[i] ? (irq_in[i] && !m_prev[i]) : irq_in[i];
                nxt[i] = m_stat[i];
                if (bus_we && bus_addr == A_ACK && bus_wdata[i]) nxt[i] = 0;
                if (m_arm && rise) nxt[i] = 1;
            end
            for (int i = 0; i < N; i++) begin
                m_stat[i] = nxt[i];
                m_prev[i] = irq_in[i];
                if (bus_we && bus_addr == A_EN)  m_en[i] = bus_wdata[i];
                if (bus_we && bus_addr == A_SET && bus_wdata[i]) m_en[i] = 1;
                if (bus_we && bus_addr == A_CLR && bus_wdata[i]) m_en[i] = 0;
            end
            if (bus_we && bus_addr == A_MST) begin m_out = bus_wdata[0]; m_arm = bus_wdata[1]; end
        end
        #1;
        if (rst_n && !done) begin
            check32("R12 model read", bus_rdata, m_read(bus_addr));
            check32("R11 model irq_out", {31'd0, irq_out}, {31'd0, m_out && (m_vec() >= 0)});
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check32(req, bus_rdata, exp);
    endtask

    task automatic chk_irq(input logic exp, input string req);
        @(negedge clk);
        #1;
        check32(req, {31'd0, irq_out}, {31'd0, exp});
    endtask

    task automatic drive(input logic [N-1:0] v);
        @(negedge clk);
        irq_in = v;
    endtask

    task automatic report();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_STAT, 32'h0, "R1 status");
        rd(A_EN, 32'h0, "R1 enable");
        rd(A_MST, 32'h0, "R1 master");
        rd(A_VEC, 32'hFFFF_FFFF, "R1 vector");
        chk_irq(1'b0, "R1 irq_out");

        // R11 capture disarmed
        drive(8'h11);
        repeat (3) @(negedge clk);
        rd(A_STAT, 32'h0, "R11 no capture while disarmed");
        drive(8'h00);

        // R2 level capture, R9 pending, R10 vector
        wr(A_MST, 32'h3);
        drive(8'h10);
        repeat (2) @(negedge clk);
        rd(A_STAT, 32'h10, "R2 level captured");
        rd(A_PEND, 32'h0, "R9 masked pending");
        chk_irq(1'b0, "R11 masked no irq");
        wr(A_SET, 32'h10);
        rd(A_PEND, 32'h10, "R9 pending");
        rd(A_VEC, 32'd4, "R10 vector index");
        chk_irq(1'b1, "R11 irq_out high");

        // R5 ack while level still high
        wr(A_ACK, 32'h10);
        rd(A_STAT, 32'h10, "R5 level re-set");
        drive(8'h00);
        wr(A_ACK, 32'h10);
        rd(A_STAT, 32'h0, "R4 ack clears");
        chk_irq(1'b0, "R11 irq_out low");

        // R3 edge held high does not re-trigger
        drive(8'h02);
        drive(8'h02);
        rd(A_STAT, 32'h02, "R3 edge captured");
        wr(A_ACK, 32'h02);
        repeat (2) @(negedge clk);
        rd(A_STAT, 32'h0, "R3 held edge no re-set");
        drive(8'h00);

        // R6 edge coincides with ack
        drive(8'h04);
        drive(8'h00);
        rd(A_STAT, 32'h04, "R6 pulse captured");
        @(negedge clk);
        irq_in = 8'h04;
        bus_we = 1'b1; bus_addr = A_ACK; bus_wdata = 32'h04;
        @(negedge clk);
        bus_we = 1'b0;
        rd(A_STAT, 32'h04, "R6 new edge wins over ack");
        drive(8'h00);

        // R4 all ones, R8 direct write, R7 aliases
        wr(A_ACK, 32'hFFFF_FFFF);
        rd(A_STAT, 32'h0, "R4 ack all ones");
        wr(A_EN, 32'h81);
        rd(A_EN, 32'h81, "R8 direct enable");
        wr(A_SET, 32'h06);
        rd(A_EN, 32'h87, "R7 set alias");
        wr(A_CLR, 32'h81);
        rd(A_EN, 32'h06, "R7 clear alias");
        wr(A_EN, 32'h0);
        rd(A_EN, 32'h0, "R8 zero disables all");

        // R12 aliases read zero
        rd(A_ACK, 32'h0, "R12 ack reads zero");
        rd(A_SET, 32'h0, "R12 set reads zero");
        rd(A_CLR, 32'h0, "R12 clr reads zero");

        // R10 priority
        wr(A_EN, 32'hFF);
        drive(8'hA0);
        @(negedge clk);
        rd(A_VEC, 32'd5, "R10 lowest of 5 and 7");
        drive(8'hA8);
        @(negedge clk);
        rd(A_STAT, 32'hA8, "R2 status accumulates");
        rd(A_VEC, 32'd3, "R10 edge bit 3 wins");
        wr(A_EN, 32'h28);
        rd(A_PEND, 32'h28, "R9 status and enable");
        wr(A_CLR, 32'h08);
        rd(A_VEC, 32'd5, "R10 after mask");

        // R11 gating by master bits
        wr(A_MST, 32'h2);
        chk_irq(1'b0, "R11 output disabled");
        rd(A_PEND, 32'h20, "R11 pending kept");
        wr(A_MST, 32'h1);
        chk_irq(1'b1, "R11 output enabled");
        drive(8'hE8);
        repeat (2) @(negedge clk);
        rd(A_STAT, 32'hA8, "R11 disarmed no new capture");
        wr(A_ACK, 32'h20);
        rd(A_STAT, 32'h88, "R11 disarmed ack sticks");
        drive(8'h00);
        repeat (3) @(negedge clk);

        report();
    end

endmodule